// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable model of a pipelined synchronous SRAM with separate read and write data ports. Each word is 36 bits, split into four 9-bit byte lanes. The depth is set by an address-width parameter. Every rising clock edge captures the address, the write data, the three chip selects, both address strobes, the advance input and the write controls. The captured access is carried out on the following edge. A read result leaves through an output register together with a valid flag.

An access begins when either address strobe loads a new external address. The host strobe always opens with a read cycle, whatever the write controls are. It can only turn into a write on a later cycle. The controller strobe decodes the write controls in its own first cycle, so a single-clock write is possible. Between loads, the advance input walks a two-bit burst offset inside an aligned block of four words, or holds the offset still. The walk follows either a linear or an interleaved order, chosen by a parameter. The write controls then decide read or write on each of those cycles. A synchronous reset clears the pipeline, the burst state and the valid flag, and leaves the stored words untouched.

Top module: `sync_burst_sram`

## Requirements
- R1: An address load takes effect only when `sel1_n_i`=0, `sel2_i`=1 and `sel3_n_i`=0 at that edge. A load with any other combination performs no write and no read, and later cycles without a load perform no access either.
- R2: When both strobes are low in the same cycle and `sel1_n_i` is low, only the host strobe counts, so the cycle is a read even if the write controls ask for a write.
- R3: The host strobe `cpu_strobe_n_i` is ignored while `sel1_n_i` is high. If no other load happens, an open burst just continues at its current address.
- R4: A host-strobe load is always a read, whatever `all_wr_n_i`, `lane_wr_n_i` and `lane_sel_n_i` say. A write to that address takes place on a later cycle that has no strobe.
- R5: A controller-strobe write completes in its load cycle at the presented address. `next_n_i` has no effect on that cycle.
- R6: `all_wr_n_i`=0 writes all four lanes and overrides `lane_wr_n_i` and `lane_sel_n_i`.
- R7: With `all_wr_n_i`=1, a write happens only when `lane_wr_n_i`=0. Lane k, meaning bits [9k+8:9k], is written only when `lane_sel_n_i[k]`=0, and the other lanes keep their contents. With `lane_wr_n_i`=1 the cycle is a read.
- R8: A read whose inputs are captured at edge N shows its data on `rdata_o`, with `rvalid_o`=1, right after edge N+1. `rvalid_o` is 0 after any cycle that was not a read.
- R9: Each cycle without a load, with `next_n_i`=0 and an open burst, advances a 2-bit step counter by one. The low two address bits become start+step mod 4 (LINEAR_BURST=1) or start XOR step (LINEAR_BURST=0). The upper address bits stay fixed, and the sequence wraps after four steps.
- R10: A cycle without a load and with `next_n_i`=1 repeats the current burst address.
- R11: A synchronous reset (`rst`=1) clears `rvalid_o`, `rdata_o`, the pipeline and the open burst. The memory contents survive it.
- R12: The chip selects are sampled only on an address load. Changing them during a burst does not stop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| sel1_n_i | input | 1 | Chip select 1, active low; also gates the host strobe |
| sel2_i | input | 1 | Chip select 2, active high |
| sel3_n_i | input | 1 | Chip select 3, active low |
| cpu_strobe_n_i | input | 1 | Host address strobe, active low, highest priority |
| ctl_strobe_n_i | input | 1 | Controller address strobe, active low |
| next_n_i | input | 1 | Burst advance, active low |
| all_wr_n_i | input | 1 | Write all lanes, active low |
| lane_wr_n_i | input | 1 | Lane write enable, active low |
| lane_sel_n_i | input | 4 | Per-lane write select, active low |
| rdata_o | output | 36 | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
Reads are started both by the controller strobe and by the host strobe. Separate checks confirm that read data appears exactly one edge after capture and that the data is valid. Four-beat bursts from start offset 1 are run on an interleaved and a linear instance. Offset 1 is chosen because the two orders give different sequences from it (5,4,7,6 against 5,6,7,4), so a mix-up between the orders shows up. The wrap back to the start is also checked. Write patterns cover an all-lane write with lane selects set against it, a two-lane write, and lane selects with the lane enable high. Together these show that the override, the per-lane masking and the fall-back to a read each work on their own. Strobe collisions, a host strobe while `sel1_n_i` is high, deselecting loads, chip-select changes during a burst and a reset during a burst each check a case where a priority or masking rule changes the result.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_decode.sv
`timescale 1ns/1ps
module sram_decode
    import sram_pkg::*;
(
    input  logic             cpu_strobe_n_i,
    input  logic             ctl_strobe_n_i,
    input  logic             sel1_n_i,
    input  logic             sel2_i,
    input  logic             sel3_n_i,
    input  logic             all_wr_n_i,
    input  logic             lane_wr_n_i,
    input  logic [LANES-1:0] lane_sel_n_i,
    input  logic             active_i,
    output logic             load_o,
    output logic             chip_on_o,
    output op_e              op_o,
    output logic [LANES-1:0] wmask_o
);
    logic             cpu_hit;
    logic             ctl_hit;
    logic [LANES-1:0] req_mask;

    always_comb begin
        // host strobe is gated by select 1 and beats the controller strobe
        cpu_hit   = !cpu_strobe_n_i && !sel1_n_i;
        ctl_hit   = !cpu_hit && !ctl_strobe_n_i;
        load_o    = cpu_hit || ctl_hit;
        chip_on_o = !sel1_n_i && sel2_i && !sel3_n_i;

        if (!all_wr_n_i)       req_mask = '1;
        else if (!lane_wr_n_i) req_mask = ~lane_sel_n_i;
        else                   req_mask = '0;

        op_o = OP_NONE;
        if (load_o) begin
            if (!chip_on_o)     op_o = OP_NONE;
            else if (cpu_hit)   op_o = OP_READ;
            else if (|req_mask) op_o = OP_WRITE;
            else                op_o = OP_READ;
        end else if (active_i) begin
            op_o = (|req_mask) ? OP_WRITE : OP_READ;
        end

        wmask_o = (op_o == OP_WRITE) ? req_mask : '0;
    end
endmodule

// File: rtl/sram_burst.sv
`timescale 1ns/1ps
module sram_burst
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit LINEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              chip_on_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              next_n_i,
    output logic              active_o,
    output logic [ADDR_W-1:0] cur_addr_o
);
    typedef struct packed {
        logic               active;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] step;
    } burst_t;

    burst_t             st_d, st_q;
    logic [BURST_W-1:0] offset;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.active = chip_on_i;
            st_d.base   = addr_i;
            st_d.step   = '0;
        end else if (st_q.active && !next_n_i) begin
            st_d.step = st_q.step + 1'b1;
        end
    end

    generate
        if (LINEAR) begin : g_linear
            assign offset = st_d.base[BURST_W-1:0] + st_d.step;
        end else begin : g_interleave
            assign offset = st_d.base[BURST_W-1:0] ^ st_d.step;
        end
    endgenerate

    assign cur_addr_o = {st_d.base[ADDR_W-1:BURST_W], offset};
    assign active_o   = st_q.active;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && !load_i && next_n_i) |=> $stable(st_q.step)); // R10
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (st_q.step == '0 && st_q.base == $past(addr_i))); // R9
    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q.active)); // R12
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  wmask_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } pipe_t;

    pipe_t             p_d, p_q;
    logic [WORD_W-1:0] mem [DEPTH];

    always_comb begin
        p_d        = p_q;
        p_d.op     = op_i;
        p_d.addr   = addr_i;
        p_d.mask   = wmask_i;
        p_d.data   = wdata_i;
        p_d.rvalid = (p_q.op == OP_READ);
        if (p_q.op == OP_READ) p_d.rdata = mem[p_q.addr];
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (!rst && p_q.op == OP_WRITE) begin
            for (int l = 0; l < LANES; l++) begin
                if (p_q.mask[l]) mem[p_q.addr][l*LANE_W +: LANE_W] <= p_q.data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata_o  = p_q.rdata;
    assign rvalid_o = p_q.rvalid;

    AST_WRITE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        (p_q.op == OP_WRITE) |=> !rvalid_o); // R7
    AST_READ_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (p_q.op == OP_READ) |=> rvalid_o); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!rvalid_o && rdata_o == '0)); // R11
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter bit LINEAR_BURST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [35:0]       wdata_i,
    input  logic              sel1_n_i,
    input  logic              sel2_i,
    input  logic              sel3_n_i,
    input  logic              cpu_strobe_n_i,
    input  logic              ctl_strobe_n_i,
    input  logic              next_n_i,
    input  logic              all_wr_n_i,
    input  logic              lane_wr_n_i,
    input  logic [3:0]        lane_sel_n_i,
    output logic [35:0]       rdata_o,
    output logic              rvalid_o
);
    logic              load;
    logic              chip_on;
    logic              active;
    op_e               op;
    logic [LANES-1:0]  wmask;
    logic [ADDR_W-1:0] cur_addr;

    sram_decode u_decode (
        .cpu_strobe_n_i (cpu_strobe_n_i),
        .ctl_strobe_n_i (ctl_strobe_n_i),
        .sel1_n_i       (sel1_n_i),
        .sel2_i         (sel2_i),
        .sel3_n_i       (sel3_n_i),
        .all_wr_n_i     (all_wr_n_i),
        .lane_wr_n_i    (lane_wr_n_i),
        .lane_sel_n_i   (lane_sel_n_i),
        .active_i       (active),
        .load_o         (load),
        .chip_on_o      (chip_on),
        .op_o           (op),
        .wmask_o        (wmask)
    );

    sram_burst #(.ADDR_W(ADDR_W), .LINEAR(LINEAR_BURST)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .chip_on_i  (chip_on),
        .addr_i     (addr_i),
        .next_n_i   (next_n_i),
        .active_o   (active),
        .cur_addr_o (cur_addr)
    );

    sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .addr_i   (cur_addr),
        .wmask_i  (wmask),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (((!cpu_strobe_n_i && !sel1_n_i) || !ctl_strobe_n_i) && !(!sel1_n_i && sel2_i && !sel3_n_i))
        |=> ##1 !rvalid_o); // R1
    AST_STROBE_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe_n_i && !ctl_strobe_n_i && !sel1_n_i && sel2_i && !sel3_n_i)
        |=> ##1 rvalid_o); // R2
    AST_HOST_FIRST_READ: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe_n_i && !sel1_n_i && sel2_i && !sel3_n_i && !all_wr_n_i)
        |=> ##1 rvalid_o); // R4
    AST_CTL_ALL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!ctl_strobe_n_i && cpu_strobe_n_i && !sel1_n_i && sel2_i && !sel3_n_i && !all_wr_n_i)
        |=> ##1 !rvalid_o); // R6
endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic [35:0] wdata;
    logic        sel1_n, sel2, sel3_n;
    logic        cpu_n, ctl_n, next_n;
    logic        all_wr_n, lane_wr_n;
    logic [3:0]  lane_sel_n;
    logic [35:0] rdata, rdata_lin;
    logic        rvalid, rvalid_lin;

    int checks = 0;
    int fails  = 0;
    logic [35:0] ref_mem [256];

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(8), .LINEAR_BURST(1'b0)) uut (
        .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata),
        .sel1_n_i(sel1_n), .sel2_i(sel2), .sel3_n_i(sel3_n),
        .cpu_strobe_n_i(cpu_n), .ctl_strobe_n_i(ctl_n), .next_n_i(next_n),
        .all_wr_n_i(all_wr_n), .lane_wr_n_i(lane_wr_n), .lane_sel_n_i(lane_sel_n),
        .rdata_o(rdata), .rvalid_o(rvalid));

    sync_burst_sram #(.ADDR_W(8), .LINEAR_BURST(1'b1)) uut_lin (
        .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata),
        .sel1_n_i(sel1_n), .sel2_i(sel2), .sel3_n_i(sel3_n),
        .cpu_strobe_n_i(cpu_n), .ctl_strobe_n_i(ctl_n), .next_n_i(next_n),
        .all_wr_n_i(all_wr_n), .lane_wr_n_i(lane_wr_n), .lane_sel_n_i(lane_sel_n),
        .rdata_o(rdata_lin), .rvalid_o(rvalid_lin));

    function automatic logic [35:0] pat(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5C, 12'hA3C};
    endfunction

    task automatic check36(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        cpu_n = 1'b1; ctl_n = 1'b1; next_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        addr = '0; wdata = '0;
    endtask

    task automatic deselect();
        go_idle();
        ctl_n = 1'b0; sel2 = 1'b0;
        tick();
        go_idle();
    endtask

    task automatic ctl_write(input logic [7:0] a, input logic [35:0] d,
                             input logic gw_n, input logic bw_n, input logic [3:0] bs_n);
        logic [3:0] m;
        go_idle();
        ctl_n = 1'b0; addr = a; wdata = d;
        all_wr_n = gw_n; lane_wr_n = bw_n; lane_sel_n = bs_n;
        tick();
        m = !gw_n ? 4'hF : (!bw_n ? ~bs_n : 4'h0);
        for (int l = 0; l < 4; l++)
            if (m[l]) ref_mem[a][l*9 +: 9] = d[l*9 +: 9];
        deselect();
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        go_idle();
        ctl_n = 1'b0; addr = a;
        tick();
        check1({req, " valid low at capture edge"}, rvalid, 1'b0);
        go_idle();
        tick();
        check1({req, " valid"}, rvalid, 1'b1);
        check36({req, " data"}, rdata, ref_mem[a]);
        deselect();
    endtask

    task automatic t_reset();
        go_idle();
        rst = 1'b1;
        repeat (3) tick();
        check1("R11 reset valid", rvalid, 1'b0);
        check36("R11 reset data", rdata, 36'h0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_preload();
        for (int a = 0; a < 16; a++) ctl_write(8'(a), pat(8'(a)), 1'b0, 1'b1, 4'hF);
        read_check("R8 single read", 8'd5);
    endtask

    task automatic t_burst_order();
        logic [7:0] ilv [4] = '{8'd5, 8'd4, 8'd7, 8'd6};
        logic [7:0] lin [4] = '{8'd5, 8'd6, 8'd7, 8'd4};
        go_idle(); cpu_n = 1'b0; addr = 8'd5;
        tick();
        for (int i = 0; i < 4; i++) begin
            go_idle(); next_n = 1'b0;
            tick();
            check36("R9 interleaved beat", rdata, ref_mem[ilv[i]]);
            check36("R9 linear beat", rdata_lin, ref_mem[lin[i]]);
        end
        go_idle();
        tick();
        check36("R9 interleaved wrap", rdata, ref_mem[8'd5]);
        check36("R9 linear wrap", rdata_lin, ref_mem[8'd5]);
        deselect();
    endtask

    task automatic t_suspend();
        go_idle(); ctl_n = 1'b0; addr = 8'd9;
        tick();
        go_idle(); tick();
        check36("R10 first", rdata, ref_mem[9]);
        go_idle(); tick();
        check36("R10 suspend", rdata, ref_mem[9]);
        go_idle(); next_n = 1'b0; tick();
        check36("R10 suspend again", rdata, ref_mem[9]);
        go_idle(); tick();
        check36("R10 advance after suspend", rdata, ref_mem[8]);
        deselect();
    endtask

    task automatic t_host_first_read();
        go_idle(); cpu_n = 1'b0; addr = 8'd8; all_wr_n = 1'b0; wdata = 36'h1_2345_6789;
        tick();
        go_idle(); all_wr_n = 1'b0; wdata = 36'hF_EDCB_A987;
        tick();
        check1("R4 first cycle read valid", rvalid, 1'b1);
        check36("R4 first cycle old data", rdata, ref_mem[8]);
        ref_mem[8] = 36'hF_EDCB_A987;
        go_idle(); tick();
        check1("R4 second cycle write", rvalid, 1'b0);
        deselect();
        read_check("R4 written", 8'd8);
    endtask

    task automatic t_strobe_priority();
        go_idle(); cpu_n = 1'b0; ctl_n = 1'b0; addr = 8'd3; all_wr_n = 1'b0; wdata = 36'h0_0000_0001;
        tick();
        go_idle(); tick();
        check1("R2 read wins", rvalid, 1'b1);
        check36("R2 data", rdata, ref_mem[3]);
        deselect();
        read_check("R2 unchanged", 8'd3);
    endtask

    task automatic t_host_ignored();
        go_idle(); ctl_n = 1'b0; addr = 8'd9;
        tick();
        go_idle(); cpu_n = 1'b0; sel1_n = 1'b1; addr = 8'd12;
        tick();
        check36("R3 burst read", rdata, ref_mem[9]);
        go_idle(); tick();
        check1("R3 valid", rvalid, 1'b1);
        check36("R3 stays on burst", rdata, ref_mem[9]);
        deselect();
    endtask

    task automatic t_ctl_write_adv();
        go_idle(); ctl_n = 1'b0; addr = 8'd10; all_wr_n = 1'b0; next_n = 1'b0; wdata = 36'h3_3333_3333;
        tick();
        ref_mem[10] = 36'h3_3333_3333;
        deselect();
        read_check("R5 written at address", 8'd10);
        read_check("R5 next untouched", 8'd11);
    endtask

    task automatic t_lane_writes();
        ctl_write(8'd11, 36'h5_5555_5555, 1'b0, 1'b0, 4'b1110);
        read_check("R6 all lanes", 8'd11);
        ctl_write(8'd12, 36'hA_AAAA_AAAA, 1'b1, 1'b0, 4'b1010);
        read_check("R7 lanes 0 and 2", 8'd12);
        go_idle(); ctl_n = 1'b0; addr = 8'd13; lane_sel_n = 4'h0; wdata = 36'h0;
        tick();
        go_idle(); tick();
        check1("R7 enable high reads", rvalid, 1'b1);
        check36("R7 enable high data", rdata, ref_mem[13]);
        deselect();
    endtask

    task automatic t_deselect();
        go_idle(); ctl_n = 1'b0; sel2 = 1'b0; addr = 8'd14; all_wr_n = 1'b0; wdata = 36'h0;
        tick();
        go_idle(); tick();
        check1("R1 no read", rvalid, 1'b0);
        go_idle(); sel3_n = 1'b1; ctl_n = 1'b0; addr = 8'd14; all_wr_n = 1'b0;
        tick();
        go_idle(); tick();
        check1("R1 still quiet", rvalid, 1'b0);
        read_check("R1 not written", 8'd14);
    endtask

    task automatic t_select_midburst();
        go_idle(); ctl_n = 1'b0; addr = 8'd0;
        tick();
        go_idle(); sel1_n = 1'b1; sel2 = 1'b0; next_n = 1'b0;
        tick();
        check36("R12 first", rdata, ref_mem[0]);
        go_idle(); sel1_n = 1'b1; sel2 = 1'b0;
        tick();
        check1("R12 burst continues", rvalid, 1'b1);
        check36("R12 advanced", rdata, ref_mem[1]);
        deselect();
    endtask

    task automatic t_reset_midburst();
        go_idle(); ctl_n = 1'b0; addr = 8'd2;
        tick();
        go_idle(); rst = 1'b1;
        tick();
        check1("R11 cleared valid", rvalid, 1'b0);
        check36("R11 cleared data", rdata, 36'h0);
        rst = 1'b0; next_n = 1'b0;
        tick();
        go_idle(); tick();
        check1("R11 burst closed", rvalid, 1'b0);
        read_check("R11 memory kept", 8'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        go_idle();
        t_reset();
        t_preload();
        t_burst_order();
        t_suspend();
        t_host_first_read();
        t_strobe_priority();
        t_host_ignored();
        t_ctl_write_adv();
        t_lane_writes();
        t_deselect();
        t_select_midburst();
        t_reset_midburst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule